// File: doc/BRIEF.md
# Bitwise Logic Unit With All Sixteen Two-Input Functions

This block takes two operand words of a set width and applies one of the sixteen possible two-input Boolean functions to every bit pair at once. A 4-bit function code picks the function. When the capture enable is high, the result is stored in an output register on the rising clock edge. When the enable is low, the register keeps its value. An active-low asynchronous reset clears the register.

The code is the truth table of the function itself. For each bit position, the two operand bits are inverted and joined as a 2-bit index, {~a, ~b}. The code bit at that index is the output bit. Each output bit is therefore a 4-to-1 multiplexer whose data inputs are the code bits and whose select lines come from the operands. No decoder is needed. The set covers the usual gates and also the selective-set and selective-clear forms used for masking fields within a word.

Top module: `bitwise_logic_unit`

## Requirements
- R1: While rst_ni is low, f_o is all zeros. Reset acts without waiting for a clock edge.
- R2: When en_i is low at a rising edge, f_o keeps its previous value whatever a_i, b_i and fn_i are.
- R3: When en_i is high at a rising edge, f_o takes the function result of the a_i, b_i and fn_i sampled at that same edge. The latency is one cycle.
- R4: Code 0 gives all zeros. Code 15 gives all ones. Neither depends on the operands.
- R5: Code 1 gives a AND b. Code 7 gives a OR b. Code 14 gives NOT (a AND b). Code 8 gives NOT (a OR b).
- R6: Code 6 gives a XOR b. Code 9 gives NOT (a XOR b).
- R7: Code 3 passes a. Code 5 passes b. Code 12 gives NOT a. Code 10 gives NOT b.
- R8: Code 2 gives a AND NOT b. Code 4 gives NOT a AND b. Code 11 gives a OR NOT b. Code 13 gives NOT a OR b.
- R9: For every bit position i, f_o[i] equals code bit {~a_i[i], ~b_i[i]}. Each bit depends only on its own operand bits and the code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Capture enable for the result register |
| fn_i | input | 4 | Function code, which is also the per-bit truth table |
| a_i | input | WIDTH | Operand a |
| b_i | input | WIDTH | Operand b |
| f_o | output | WIDTH | Registered result |

## Verification
The following properties are checked at every clock edge:
- the register stays zero while reset is held (R1);
- the register holds whenever enable is low (R2);
- every enabled capture matches a behavioural description of the selected function, written one case per code (R3 to R8);
- the clear and set codes give constant outputs (R4).

The bench covers what those properties cannot show on their own:
- the exact code-to-function mapping, through a fixed table of known operands and hand-computed results;
- that each bit follows the truth-table indexing independently, through walking-one patterns and corner patterns (R9);
- that reset clears the register in the middle of a run, without a clock edge.

// File: rtl/lu_pkg.sv
package lu_pkg;
  localparam int unsigned FN_W = 4;
  typedef logic [FN_W-1:0] lu_fn_t;

  localparam lu_fn_t FN_ZERO  = 4'd0;
  localparam lu_fn_t FN_AND   = 4'd1;
  localparam lu_fn_t FN_ANDNB = 4'd2;
  localparam lu_fn_t FN_PASSA = 4'd3;
  localparam lu_fn_t FN_NAANDB= 4'd4;
  localparam lu_fn_t FN_PASSB = 4'd5;
  localparam lu_fn_t FN_XOR   = 4'd6;
  localparam lu_fn_t FN_OR    = 4'd7;
  localparam lu_fn_t FN_NOR   = 4'd8;
  localparam lu_fn_t FN_XNOR  = 4'd9;
  localparam lu_fn_t FN_NOTB  = 4'd10;
  localparam lu_fn_t FN_AORNB = 4'd11;
  localparam lu_fn_t FN_NOTA  = 4'd12;
  localparam lu_fn_t FN_NAORB = 4'd13;
  localparam lu_fn_t FN_NAND  = 4'd14;
  localparam lu_fn_t FN_ONES  = 4'd15;
endpackage

// File: rtl/lu_bit_mux.sv
module lu_bit_mux
  import lu_pkg::*;
(
  input  lu_fn_t tt_i,
  input  logic   a_i,
  input  logic   b_i,
  output logic   f_o
);
  logic [1:0] sel;
  // truth table index is the inverted operand pair
  assign sel = {~a_i, ~b_i};
  always_comb begin
    unique case (sel)
      2'd0: f_o = tt_i[0];
      2'd1: f_o = tt_i[1];
      2'd2: f_o = tt_i[2];
      default: f_o = tt_i[3];
    endcase
  end
endmodule

// File: rtl/lu_logic_array.sv
module lu_logic_array
  import lu_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  lu_fn_t           fn_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] f_o
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    lu_bit_mux u_mux (
      .tt_i (fn_i),
      .a_i  (a_i[i]),
      .b_i  (b_i[i]),
      .f_o  (f_o[i])
    );
  end
endmodule

// File: rtl/lu_result_reg.sv
module lu_result_reg #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (en_i) q_o <= d_i;
  end
endmodule

// File: rtl/bitwise_logic_unit.sv
module bitwise_logic_unit
  import lu_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [3:0]       fn_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] f_o
);
  logic [WIDTH-1:0] comb_f;

  lu_logic_array #(.WIDTH(WIDTH)) u_array (
    .fn_i (fn_i),
    .a_i  (a_i),
    .b_i  (b_i),
    .f_o  (comb_f)
  );

  lu_result_reg #(.WIDTH(WIDTH)) u_reg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .d_i    (comb_f),
    .q_o    (f_o)
  );
endmodule

// File: rtl/lu_checker.sv
module lu_checker
  import lu_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic [3:0]       fn_i,
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic [WIDTH-1:0] f_o
);
  function automatic logic [WIDTH-1:0] ref_fn(lu_fn_t c, logic [WIDTH-1:0] a, logic [WIDTH-1:0] b);
    case (c)
      FN_ZERO:   return '0;
      FN_AND:    return a & b;
      FN_ANDNB:  return a & ~b;
      FN_PASSA:  return a;
      FN_NAANDB: return ~a & b;
      FN_PASSB:  return b;
      FN_XOR:    return a ^ b;
      FN_OR:     return a | b;
      FN_NOR:    return ~(a | b);
      FN_XNOR:   return ~(a ^ b);
      FN_NOTB:   return ~b;
      FN_AORNB:  return a | ~b;
      FN_NOTA:   return ~a;
      FN_NAORB:  return ~a | b;
      FN_NAND:   return ~(a & b);
      default:   return '1;
    endcase
  endfunction

  logic [WIDTH-1:0] exp_f;
  assign exp_f = ref_fn(fn_i, a_i, b_i);

  // R1
  always @(posedge clk_i) begin
    if (!rst_ni) a_r1_reset_zero: assert (f_o == '0);
  end

  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(f_o));

  // R3..R8 behavioural match, R9 implied per bit
  a_r3_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> f_o == $past(exp_f));

  a_r4_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && fn_i == FN_ZERO) |=> f_o == '0);

  a_r4_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && fn_i == FN_ONES) |=> f_o == '1);
endmodule

bind bitwise_logic_unit lu_checker #(.WIDTH(WIDTH)) u_lu_checker (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .en_i   (en_i),
  .fn_i   (fn_i),
  .a_i    (a_i),
  .b_i    (b_i),
  .f_o    (f_o)
);

// File: tb/bitwise_logic_unit_tb_top.sv
module bitwise_logic_unit_tb_top;
  localparam int unsigned W = 8;
  localparam int unsigned NVEC = 16;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         en_i = 1'b0;
  logic [3:0]   fn_i = '0;
  logic [W-1:0] a_i = '0;
  logic [W-1:0] b_i = '0;
  logic [W-1:0] f_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  bitwise_logic_unit #(.WIDTH(W)) dut_i (.*);

  // a=CC b=AA; entry k is code k
  localparam logic [W-1:0] EXP_TAB [NVEC] = '{
    8'h00, 8'h88, 8'h44, 8'hCC, 8'h22, 8'hAA, 8'h66, 8'hEE,
    8'h11, 8'h99, 8'h55, 8'hDD, 8'h33, 8'hBB, 8'h77, 8'hFF };
  localparam string REQ_TAB [NVEC] = '{
    "R4", "R5", "R8", "R7", "R8", "R7", "R6", "R5",
    "R5", "R6", "R7", "R8", "R7", "R8", "R5", "R4" };

  function automatic logic [W-1:0] model(logic [3:0] c, logic [W-1:0] a, logic [W-1:0] b);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) r[i] = c[{~a[i], ~b[i]}];
    return r;
  endfunction

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: f_o=%h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(logic en, logic [3:0] c, logic [W-1:0] a, logic [W-1:0] b);
    @(negedge clk_i);
    en_i = en; fn_i = c; a_i = a; b_i = b;
    @(negedge clk_i);
  endtask

  initial begin
    logic [W-1:0] held;
    repeat (3) @(negedge clk_i);
    check("R1", f_o, '0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1", f_o, '0);

    // table walk: R4..R8, R3
    for (int k = 0; k < NVEC; k++) begin
      apply(1'b1, 4'(k), 8'hCC, 8'hAA);
      check(REQ_TAB[k], f_o, EXP_TAB[k]);
    end

    // R9 walking ones, all codes
    for (int c = 0; c < 16; c++) begin
      for (int i = 0; i < W; i++) begin
        apply(1'b1, 4'(c), 8'(1 << i), 8'hF0);
        check("R9", f_o, model(4'(c), 8'(1 << i), 8'hF0));
      end
    end

    // R3 random operands, all codes
    for (int n = 0; n < 64; n++) begin
      logic [W-1:0] ra, rb;
      ra = 8'($urandom); rb = 8'($urandom);
      apply(1'b1, 4'(n % 16), ra, rb);
      check("R3", f_o, model(4'(n % 16), ra, rb));
    end

    // R4 corner operands
    apply(1'b1, 4'd0, 8'hFF, 8'hFF);
    check("R4", f_o, 8'h00);
    apply(1'b1, 4'd15, 8'h00, 8'h00);
    check("R4", f_o, 8'hFF);

    // R2 hold with enable low
    apply(1'b1, 4'd6, 8'h5A, 8'h0F);
    held = f_o;
    check("R3", held, 8'h55);
    apply(1'b0, 4'd15, 8'h00, 8'h00);
    check("R2", f_o, held);
    apply(1'b0, 4'd0, 8'hFF, 8'hFF);
    check("R2", f_o, held);

    // R3 one-cycle latency: first edge after enable
    @(negedge clk_i);
    en_i = 1'b1; fn_i = 4'd12; a_i = 8'h0F; b_i = 8'h00;
    @(posedge clk_i); #1;
    check("R3", f_o, 8'hF0);
    en_i = 1'b0;

    // R1 asynchronous reset mid-run
    @(negedge clk_i);
    #1 rst_ni = 1'b0;
    #0.5;
    check("R1", f_o, '0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1", f_o, '0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule